// File: doc/BRIEF.md
# Sector-Mapped Cache Tag Controller

This block keeps the tags and per-line valid bits of a sector-mapped cache with a 32-bit byte address. A sector is four consecutive 64-byte refill lines. Each cache entry holds one sector tag and four line-valid bits, and any memory sector may sit in any entry. The tag match is fully associative. The data array and the memory bus are outside the block.

A lookup is presented with `lkp_valid` and `lkp_addr` while the controller is idle. One cycle later `res_valid` pulses with the result class and the entry concerned. The result class is one of three: a hit, a line miss (the sector is present but the line is not), or a sector miss (no entry holds the sector). For either kind of miss the controller enters its refill state. In that state it raises `fill_req` with the line-aligned address and holds `busy` until `fill_done` arrives. It then updates the tag store and returns to idle.

The controller has two states. `ST_IDLE` accepts lookups. On a hit it stays in `ST_IDLE`. On a line miss or a sector miss it moves to `ST_REFILL`. `ST_REFILL` waits for `fill_done`, writes the tag store, and returns to `ST_IDLE`.

Top module: `sector_tag_ctrl`

## Requirements
- R1: Address bits [31:8] form the sector tag, bits [7:6] select the line within the sector, and bits [5:0] are ignored by the lookup. `fill_addr` is bits [31:6] of the missed address with six zero bits appended.
- R2: A lookup accepted at a clock edge gives `res_valid` high for exactly the next cycle. `res_kind` is coded 2'b00 for a hit, 2'b01 for a line miss and 2'b10 for a sector miss.
- R3: Tag matching is fully associative. On a hit or a line miss, `res_entry` is the index of the entry holding the sector.
- R4: On a line miss, the refill sets only the missed line's valid bit. The entry's tag and its other valid bits stay unchanged.
- R5: On a sector miss, `res_entry` is the lowest-numbered entry with no valid line. If every entry holds a sector, `res_entry` is the least recently used entry. An entry counts as used when it hits or when a refill into it completes.
- R6: When a sector miss completes, the chosen entry takes the new tag. Its valid bits become exactly the fetched line; the other three lines are invalid.
- R7: After a miss is reported, `busy` and `fill_req` stay high until the edge at which `fill_done` is sampled high, and both are low in the cycle after.
- R8: A lookup presented while `busy` is high is ignored: no result is reported and the tag store is unchanged.
- R9: Reset clears every valid bit and leaves `res_valid`, `busy` and `fill_req` low.
- R10: A hit starts no refill: `busy` and `fill_req` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_valid | input | 1 | Lookup request |
| lkp_addr | input | 32 | Lookup byte address |
| fill_done | input | 1 | Memory has delivered the requested line |
| res_valid | output | 1 | One-cycle pulse carrying a lookup result |
| res_kind | output | 2 | Hit / line miss / sector miss code |
| res_entry | output | 3 | Matching entry, or the chosen victim on a sector miss |
| busy | output | 1 | Refill outstanding; lookups are not taken |
| fill_req | output | 1 | Line refill request |
| fill_addr | output | 32 | Line-aligned address of the requested line |

## Verification
The hardest situation to reach is a reallocation under full occupancy. It needs every entry valid, a victim that is chosen by recency rather than by index, and a later line miss that exposes the three lines invalidated by the reallocation. The stimulus fills all eight entries in order and then re-touches entry 0 with a hit, so the least recently used entry becomes entry 1. It then brings in a new sector, which must land in entry 1. Finally it probes another line of that sector, which must report a line miss. Stray lookups are pulsed during every refill to show that they leave no trace.

// File: rtl/sector_cache_pkg.sv
package sector_cache_pkg;
    typedef enum logic [1:0] {
        RES_HIT         = 2'b00,
        RES_LINE_MISS   = 2'b01,
        RES_SECTOR_MISS = 2'b10
    } lookup_kind_e;

    typedef enum logic {
        ST_IDLE,
        ST_REFILL
    } ctrl_state_e;
endpackage

// File: rtl/sector_match.sv
module sector_match #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 24,
    parameter int LINES   = 4,
    parameter int IDX_W   = 3
) (
    input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
    input  logic [ENTRIES-1:0][LINES-1:0] valids,
    input  logic [TAG_W-1:0]              probe,
    output logic [ENTRIES-1:0]            match_vec,
    output logic                          hit,
    output logic [IDX_W-1:0]              hit_idx,
    output logic [LINES-1:0]              hit_lines
);
    // one comparator per entry; an entry with no valid line never matches
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = (|valids[g]) && (tags[g] == probe);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) hit_idx = IDX_W'(i);
        end
        hit       = |match_vec;
        hit_lines = valids[hit_idx];
    end
endmodule

// File: rtl/sector_lru.sv
module sector_lru #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic [ENTRIES-1:0] empty_vec,
    output logic [IDX_W-1:0]   victim_idx
);
    localparam logic [IDX_W-1:0] AGE_MAX = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0][IDX_W-1:0] age_q;
    logic [ENTRIES-1:0]            oldest_vec;

    // ages form a permutation of 0..ENTRIES-1; 0 is most recent
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
        end else if (touch) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx)          age_q[i] <= '0;
                else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_old
        assign oldest_vec[g] = (age_q[g] == AGE_MAX);
    end

    always_comb begin
        logic found;
        found      = 1'b0;
        victim_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (empty_vec[i] && !found) begin
                victim_idx = IDX_W'(i);
                found      = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (oldest_vec[i]) victim_idx = IDX_W'(i);
            end
        end
    end

    // R5
    lru_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest_vec) == 1);
endmodule

// File: rtl/sector_tag_ctrl.sv
module sector_tag_ctrl #(
    parameter int ENTRIES    = 8,
    parameter int ADDR_W     = 32,
    parameter int OFFSET_W   = 6,
    parameter int LINE_SEL_W = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lkp_valid,
    input  logic [ADDR_W-1:0]          lkp_addr,
    input  logic                       fill_done,
    output logic                       res_valid,
    output logic [1:0]                 res_kind,
    output logic [$clog2(ENTRIES)-1:0] res_entry,
    output logic                       busy,
    output logic                       fill_req,
    output logic [ADDR_W-1:0]          fill_addr
);
    import sector_cache_pkg::*;

    localparam int LINES = 1 << LINE_SEL_W;
    localparam int TAG_W = ADDR_W - OFFSET_W - LINE_SEL_W;
    localparam int IDX_W = $clog2(ENTRIES);

    ctrl_state_e                   state_q, state_d;
    logic [ENTRIES-1:0][TAG_W-1:0] tags_q;
    logic [ENTRIES-1:0][LINES-1:0] valid_q;
    logic [TAG_W-1:0]              req_tag_q;
    logic [LINE_SEL_W-1:0]         req_line_q;
    logic [IDX_W-1:0]              req_idx_q;
    lookup_kind_e                  req_kind_q;
    logic                          res_valid_q;

    logic [TAG_W-1:0]      probe_tag;
    logic [LINE_SEL_W-1:0] probe_line;
    logic [ENTRIES-1:0]    match_vec, empty_vec;
    logic                  hit;
    logic [IDX_W-1:0]      hit_idx, victim_idx, touch_idx;
    logic [LINES-1:0]      hit_lines;
    lookup_kind_e          kind_now;
    logic                  accept, finish, touch;

    assign probe_tag  = lkp_addr[ADDR_W-1 -: TAG_W];
    assign probe_line = lkp_addr[OFFSET_W +: LINE_SEL_W];

    sector_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .LINES(LINES), .IDX_W(IDX_W)) u_match (
        .tags(tags_q), .valids(valid_q), .probe(probe_tag),
        .match_vec(match_vec), .hit(hit), .hit_idx(hit_idx), .hit_lines(hit_lines)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_empty
        assign empty_vec[g] = ~|valid_q[g];
    end

    sector_lru #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lru (
        .clk(clk), .rst_n(rst_n), .touch(touch), .touch_idx(touch_idx),
        .empty_vec(empty_vec), .victim_idx(victim_idx)
    );

    assign accept = (state_q == ST_IDLE) && lkp_valid;
    assign finish = (state_q == ST_REFILL) && fill_done;

    always_comb begin
        if (!hit)                 kind_now = RES_SECTOR_MISS;
        else if (hit_lines[probe_line]) kind_now = RES_HIT;
        else                      kind_now = RES_LINE_MISS;
    end

    assign touch     = (accept && kind_now == RES_HIT) || finish;
    assign touch_idx = (state_q == ST_REFILL) ? req_idx_q : hit_idx;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept && kind_now != RES_HIT) state_d = ST_REFILL;
            ST_REFILL: if (fill_done)                     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request capture and tag store
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid_q <= 1'b0;
            req_tag_q   <= '0;
            req_line_q  <= '0;
            req_idx_q   <= '0;
            req_kind_q  <= RES_HIT;
            tags_q      <= '0;
            valid_q     <= '0;
        end else begin
            res_valid_q <= accept;
            if (accept) begin
                req_tag_q  <= probe_tag;
                req_line_q <= probe_line;
                req_kind_q <= kind_now;
                req_idx_q  <= (kind_now == RES_SECTOR_MISS) ? victim_idx : hit_idx;
            end
            if (finish) begin
                if (req_kind_q == RES_SECTOR_MISS) begin
                    tags_q[req_idx_q]  <= req_tag_q;
                    valid_q[req_idx_q] <= LINES'(1) << req_line_q;
                end else begin
                    valid_q[req_idx_q][req_line_q] <= 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        res_valid = res_valid_q;
        res_kind  = req_kind_q;
        res_entry = req_idx_q;
        busy      = (state_q == ST_REFILL);
        fill_req  = (state_q == ST_REFILL);
        fill_addr = {req_tag_q, req_line_q, {OFFSET_W{1'b0}}};
    end

    // R3
    tag_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));
    // R7
    refill_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fill_done) |=> !busy && !fill_req);
    // R2
    miss_enters_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind != RES_HIT) |-> busy);
    // R6
    realloc_single_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && req_kind_q == RES_SECTOR_MISS) |=> $countones(valid_q[req_idx_q]) == 1);
    // R4
    line_fill_keeps_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && req_kind_q == RES_LINE_MISS) |=> $stable(tags_q));
    // R8
    busy_ignores_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && lkp_valid) |=> !res_valid);
endmodule

// File: tb/sector_tag_ctrl_test.sv
module sector_tag_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lkp_valid = 1'b0;
    logic [31:0] lkp_addr = '0;
    logic        fill_done = 1'b0;
    logic        res_valid, busy, fill_req;
    logic [1:0]  res_kind;
    logic [2:0]  res_entry;
    logic [31:0] fill_addr;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    always #10 clk = ~clk;

    sector_tag_ctrl uut (
        .clk(clk), .rst_n(rst_n), .lkp_valid(lkp_valid), .lkp_addr(lkp_addr),
        .fill_done(fill_done), .res_valid(res_valid), .res_kind(res_kind),
        .res_entry(res_entry), .busy(busy), .fill_req(fill_req), .fill_addr(fill_addr)
    );

    localparam logic [1:0] K_HIT = 2'b00, K_LM = 2'b01, K_SM = 2'b10;
    localparam int NVEC = 20;
    // {address, expected kind, expected entry}
    localparam logic [36:0] VEC [NVEC] = '{
        {32'hA700_0105, K_SM,  3'd0},  // R1 R5: first empty entry
        {32'hA700_013F, K_HIT, 3'd0},  // R1 R10: offset ignored
        {32'hA700_0180, K_LM,  3'd0},  // R4
        {32'hA700_01A2, K_HIT, 3'd0},  // R4
        {32'hA700_0140, K_LM,  3'd0},  // R4
        {32'hA700_02C0, K_SM,  3'd1},  // R5
        {32'hA700_0300, K_SM,  3'd2},
        {32'hA700_0400, K_SM,  3'd3},
        {32'hA700_0500, K_SM,  3'd4},
        {32'hA700_0600, K_SM,  3'd5},
        {32'hA700_0700, K_SM,  3'd6},
        {32'hA700_0800, K_SM,  3'd7},
        {32'hA700_0100, K_HIT, 3'd0},  // R3 R5: refresh entry 0
        {32'hFF00_0940, K_SM,  3'd1},  // R5: LRU victim
        {32'hA700_02C4, K_SM,  3'd2},  // R5: evicted sector misses
        {32'hFF00_0900, K_LM,  3'd1},  // R6: other lines invalid
        {32'hFF00_0950, K_HIT, 3'd1},  // R6
        {32'hA700_01C0, K_LM,  3'd0},  // R4
        {32'hA700_0188, K_HIT, 3'd0},  // R4: earlier lines kept
        {32'hA700_0155, K_HIT, 3'd0}   // R4 R8
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic lookup(input logic [31:0] a, input logic [1:0] k, input logic [2:0] e);
        @(negedge clk);
        lkp_valid = 1'b1;
        lkp_addr  = a;
        @(negedge clk);
        lkp_valid = 1'b0;
        chk(res_valid == 1'b1, "R2 res_valid", res_valid, 1);
        chk(res_kind == k, "R2/R4/R5 res_kind", res_kind, k);
        chk(res_entry == e, "R3/R5 res_entry", res_entry, e);
        if (k == K_HIT) begin
            chk(busy == 1'b0 && fill_req == 1'b0, "R10 no refill", {busy, fill_req}, 0);
        end else begin
            chk(busy && fill_req, "R7 busy during refill", {busy, fill_req}, 3);
            chk(fill_addr == {a[31:6], 6'b0}, "R1 fill_addr", fill_addr, {a[31:6], 6'b0});
            lkp_valid = 1'b1;
            lkp_addr  = 32'h1234_5600;
            @(negedge clk);
            lkp_valid = 1'b0;
            chk(res_valid == 1'b0, "R8 lookup ignored while busy", res_valid, 0);
            chk(busy == 1'b1, "R7 busy held", busy, 1);
            fill_done = 1'b1;
            @(negedge clk);
            fill_done = 1'b0;
            chk(busy == 1'b0 && fill_req == 1'b0, "R7 idle after done", {busy, fill_req}, 0);
            chk(res_valid == 1'b0, "R8 no stray result", res_valid, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(res_valid == 0 && busy == 0 && fill_req == 0, "R9 reset outputs",
            {res_valid, busy, fill_req}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            lookup(VEC[i][36:5], VEC[i][4:3], VEC[i][2:0]);
        end
        // reset mid-life clears every valid bit
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(res_valid == 0 && busy == 0 && fill_req == 0, "R9 reset outputs again",
            {res_valid, busy, fill_req}, 0);
        rst_n = 1'b1;
        lookup(32'hA700_0100, K_SM, 3'd0);   // R9: former hit now misses
        lookup(32'hFF00_0940, K_SM, 3'd1);   // R9
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule